// File: doc/BRIEF.md
# Rectangle Read-Out Word Packer

This block copies a rectangle of pixels out of a byte-addressed display frame buffer and streams it to a host as 16-bit words. Software supplies the byte address of the rectangle's top-left pixel, the rectangle size as width-minus-one and height-minus-one, the distance between lines in 16-bit words, a pixel size select (one-byte or two-byte pixels) and a one-bit byte phase. A single-cycle start pulse launches the transfer. The block then walks the rectangle in row-major order, reading one pixel at a time through a request/response memory port, and emits packed words on a valid/ready stream.

With two-byte pixels each word is one pixel. With one-byte pixels two pixels share a word. The phase bit selects whether the first pixel of each line sits in the upper or the lower byte of that line's first word. So the number of words per line is the width plus the phase, halved and rounded up. Any byte that carries no pixel is driven as zero. A sticky done flag reports the end of the transfer. While the host holds ready low, the block waits and issues no new memory reads.

The start address of a rectangle at column x and row y is y times the screen stride in bytes plus x times the bytes per pixel, where the screen stride is the display width in pixels times the bytes per pixel.

Top module: `rblit_packer`

## Requirements
- R1: After reset, out_valid, mem_req, busy and done are all 0.
- R2: In byte-pixel mode (pix16=0) with phase=0, each line's first pixel goes into out_data[7:0] and its second pixel into out_data[15:8]. Later pixels keep alternating low, then high.
- R3: In byte-pixel mode with phase=1, each line's first pixel goes into out_data[15:8] and out_data[7:0] of that word is 0. Later pixels alternate low, then high.
- R4: In byte-pixel mode, a final word of a line that holds one pixel carries it in out_data[7:0], with out_data[15:8] equal to 0.
- R5: Each line produces ceil((width_m1+1+phase)/2) words in byte-pixel mode and width_m1+1 words in two-byte mode. The blit produces that count times (height_m1+1) words, and packing restarts at the phase position on every line.
- R6: In two-byte mode (pix16=1), each word is the 16-bit memory response for one pixel, and pixel addresses within a line step by 2.
- R7: Pixel x of line y is read from byte address src_addr + 2*stride_w*y + x*(1+pix16), modulo 2^ADDR_W. The memory returns mem_rdata[7:0] from the addressed byte and mem_rdata[15:8] from the next byte. Byte mode uses only mem_rdata[7:0].
- R8: While out_valid=1 and out_ready=0, out_data holds steady and mem_req stays 0.
- R9: done rises in the cycle after the last word is accepted. It stays 1 with busy=0 until the next start, which clears it.
- R10: A start pulse while busy=1 has no effect, and changes on the configuration inputs during a blit do not alter its output.
- R11: At most one memory read is outstanding: mem_req is a single-cycle pulse and is not raised again until mem_rvalid has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle launch pulse, taken only when idle |
| src_addr | input | ADDR_W | Byte address of the top-left pixel |
| width_m1 | input | WID_W | Pixels per line minus one |
| height_m1 | input | HGT_W | Lines minus one |
| stride_w | input | STR_W | Line-to-line distance in 16-bit words |
| pix16 | input | 1 | 0: one-byte pixels, 1: two-byte pixels |
| phase | input | 1 | Byte-mode first-pixel position: 0 low byte, 1 high byte |
| mem_req | output | 1 | Single-cycle read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 16 | Read response data |
| out_valid | output | 1 | Packed word available |
| out_data | output | 16 | Packed word |
| out_ready | input | 1 | Host accepts the word |
| busy | output | 1 | Blit in progress |
| done | output | 1 | Last blit finished (sticky) |

## Verification
The hardest situation to reach is the end-of-line word in byte mode. Whether it ends half filled depends on both the width and the phase, and it must coincide with a host stall and with the restart of packing on the next line. The stimulus table therefore pairs odd and even widths with both phases and single-pixel lines, and it runs several vectors with a sink that accepts only every third cycle. A directed run holds ready low for several cycles on the first word, and another fires a second start with different settings mid-blit to show the first blit's output is unchanged.

// File: rtl/rblit_pkg.sv
package rblit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_OUT
    } rb_state_e;
endpackage

// File: rtl/rblit_walker.sv
module rblit_walker #(
    parameter int ADDR_W = 16,
    parameter int WID_W  = 10,
    parameter int HGT_W  = 10,
    parameter int STR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [WID_W-1:0]  width_m1,
    input  logic [HGT_W-1:0]  height_m1,
    input  logic [STR_W-1:0]  stride_w,
    input  logic              pix16,
    output logic [ADDR_W-1:0] pix_addr,
    output logic              line_end,
    output logic              blit_end
);
    typedef struct packed {
        logic [WID_W-1:0]  col;
        logic [HGT_W-1:0]  row;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] addr;
        logic [WID_W-1:0]  wm1;
        logic [HGT_W-1:0]  hm1;
        logic [STR_W-1:0]  stride;
        logic              two_byte;
    } walk_s;

    walk_s w_d, w_q;
    logic [ADDR_W-1:0] line_step;
    logic [ADDR_W-1:0] next_base;

    always_comb begin
        line_step = ADDR_W'({w_q.stride, 1'b0});
        next_base = w_q.base + line_step;
        w_d = w_q;
        if (load) begin
            w_d.col      = '0;
            w_d.row      = '0;
            w_d.base     = src_addr;
            w_d.addr     = src_addr;
            w_d.wm1      = width_m1;
            w_d.hm1      = height_m1;
            w_d.stride   = stride_w;
            w_d.two_byte = pix16;
        end else if (adv) begin
            if (w_q.col == w_q.wm1) begin
                w_d.col  = '0;
                w_d.row  = w_q.row + 1'b1;
                w_d.base = next_base;
                w_d.addr = next_base;
            end else begin
                w_d.col  = w_q.col + 1'b1;
                w_d.addr = w_q.addr + (w_q.two_byte ? ADDR_W'(2) : ADDR_W'(1));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign pix_addr = w_q.addr;
    assign line_end = (w_q.col == w_q.wm1);
    assign blit_end = line_end && (w_q.row == w_q.hm1);

    // R5
    col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.col <= w_q.wm1);
    // R5
    row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.row <= w_q.hm1);
endmodule

// File: rtl/rblit_ctrl.sv
module rblit_ctrl
    import rblit_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pix16,
    input  logic              phase,
    output logic              load,
    output logic              adv,
    input  logic              line_end,
    input  logic              blit_end,
    input  logic [ADDR_W-1:0] pix_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [15:0]       mem_rdata,
    output logic              out_valid,
    output logic [15:0]       out_data,
    input  logic              out_ready,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        rb_state_e   state;
        logic [15:0] word;
        logic        hi;
        logic        two_byte;
        logic        ph;
        logic        fin;
    } ctrl_s;

    ctrl_s c_d, c_q;

    always_comb begin
        c_d  = c_q;
        load = 1'b0;
        adv  = 1'b0;
        unique case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    load         = 1'b1;
                    c_d.state    = ST_REQ;
                    c_d.two_byte = pix16;
                    c_d.ph       = phase;
                    c_d.hi       = phase & ~pix16;
                    c_d.word     = '0;
                    c_d.fin      = 1'b0;
                end
            end
            ST_REQ: c_d.state = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid) begin
                    if (c_q.two_byte) begin
                        c_d.word  = mem_rdata;
                        c_d.state = ST_OUT;
                    end else if (c_q.hi) begin
                        c_d.word[15:8] = mem_rdata[7:0];
                        c_d.state      = ST_OUT;
                    end else begin
                        c_d.word[7:0] = mem_rdata[7:0];
                        if (line_end) begin
                            c_d.state = ST_OUT;
                        end else begin
                            c_d.hi    = 1'b1;
                            adv       = 1'b1;
                            c_d.state = ST_REQ;
                        end
                    end
                end
            end
            ST_OUT: begin
                if (out_ready) begin
                    c_d.word = '0;
                    if (blit_end) begin
                        c_d.state = ST_IDLE;
                        c_d.fin   = 1'b1;
                    end else begin
                        adv       = 1'b1;
                        c_d.hi    = line_end ? (c_q.ph & ~c_q.two_byte) : 1'b0;
                        c_d.state = ST_REQ;
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{state: ST_IDLE, default: '0};
        else        c_q <= c_d;
    end

    assign mem_req   = (c_q.state == ST_REQ);
    assign mem_addr  = pix_addr;
    assign out_valid = (c_q.state == ST_OUT);
    assign out_data  = c_q.word;
    assign busy      = (c_q.state != ST_IDLE);
    assign done      = c_q.fin;

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R8
    no_read_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_req);
    // R11
    one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !out_valid);
endmodule

// File: rtl/rblit_packer.sv
module rblit_packer #(
    parameter int ADDR_W = 16,
    parameter int WID_W  = 10,
    parameter int HGT_W  = 10,
    parameter int STR_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [WID_W-1:0]  width_m1,
    input  logic [HGT_W-1:0]  height_m1,
    input  logic [STR_W-1:0]  stride_w,
    input  logic              pix16,
    input  logic              phase,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [15:0]       mem_rdata,
    output logic              out_valid,
    output logic [15:0]       out_data,
    input  logic              out_ready,
    output logic              busy,
    output logic              done
);
    logic              load, adv, line_end, blit_end;
    logic [ADDR_W-1:0] pix_addr;

    rblit_walker #(
        .ADDR_W(ADDR_W), .WID_W(WID_W), .HGT_W(HGT_W), .STR_W(STR_W)
    ) walk_i (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
        .src_addr(src_addr), .width_m1(width_m1), .height_m1(height_m1),
        .stride_w(stride_w), .pix16(pix16), .pix_addr(pix_addr),
        .line_end(line_end), .blit_end(blit_end)
    );

    rblit_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pix16(pix16), .phase(phase),
        .load(load), .adv(adv), .line_end(line_end), .blit_end(blit_end),
        .pix_addr(pix_addr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .busy(busy), .done(done)
    );
endmodule

// File: tb/rblit_packer_tb.sv
module rblit_packer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] src_addr = '0;
    logic [9:0]  width_m1 = '0;
    logic [9:0]  height_m1 = '0;
    logic [9:0]  stride_w = '0;
    logic        pix16 = 1'b0;
    logic        phase = 1'b0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_ready = 1'b0;
    logic        busy, done;

    always #10 clk = ~clk;

    rblit_packer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
        .width_m1(width_m1), .height_m1(height_m1), .stride_w(stride_w),
        .pix16(pix16), .phase(phase), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [15:0] src;
        logic [9:0]  wm1;
        logic [9:0]  hm1;
        logic [9:0]  stride;
        logic        two;
        logic        ph;
        logic [1:0]  stall;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'd100,   10'd4,  10'd2,  10'd20,  1'b0, 1'b0, 2'd0},
        '{16'd101,   10'd4,  10'd2,  10'd20,  1'b0, 1'b1, 2'd1},
        '{16'd64,    10'd5,  10'd1,  10'd16,  1'b0, 1'b1, 2'd0},
        '{16'd200,   10'd3,  10'd3,  10'd32,  1'b1, 1'b0, 2'd1},
        '{16'd10,    10'd0,  10'd0,  10'd8,   1'b0, 1'b0, 2'd0},
        '{16'd11,    10'd0,  10'd2,  10'd8,   1'b0, 1'b1, 2'd1},
        '{16'd24345, 10'd99, 10'd19, 10'd320, 1'b0, 1'b0, 2'd0}
    };

    int checks = 0;
    int fails = 0;
    int sink_mode = 0;
    int cyc = 0;
    logic [15:0] exp_q[$];
    logic [15:0] got_q[$];
    logic [15:0] p_addr = '0;
    bit          p_pend = 1'b0;

    function automatic logic [7:0] pat(input logic [15:0] a);
        logic [15:0] t;
        t = a * 16'd37 + 16'd5;
        return t[7:0] | 8'h01;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model and host sink, both driven away from the active edge
    always @(negedge clk) begin
        bit rdy;
        cyc++;
        mem_rvalid = 1'b0;
        if (p_pend) begin
            mem_rvalid = 1'b1;
            mem_rdata  = {pat(p_addr + 16'd1), pat(p_addr)};
            p_pend     = 1'b0;
        end
        if (mem_req) begin
            p_addr = mem_addr;
            p_pend = 1'b1;
        end
        case (sink_mode)
            0:       rdy = 1'b1;
            1:       rdy = (cyc % 3 == 0);
            default: rdy = 1'b0;
        endcase
        out_ready = rdy;
        if (out_valid && rdy) got_q.push_back(out_data);
    end

    task automatic build_exp(input vec_t v);
        exp_q.delete();
        for (int y = 0; y <= int'(v.hm1); y++) begin
            logic [15:0] base;
            logic [15:0] w;
            bit hi;
            base = v.src + 16'(y * 2 * int'(v.stride));
            hi = v.ph;
            w = '0;
            for (int x = 0; x <= int'(v.wm1); x++) begin
                if (v.two) begin
                    logic [15:0] a;
                    a = base + 16'(2 * x);
                    exp_q.push_back({pat(a + 16'd1), pat(a)});
                end else begin
                    logic [7:0] b;
                    b = pat(base + 16'(x));
                    if (hi) begin
                        w[15:8] = b;
                        exp_q.push_back(w);
                        w = '0;
                        hi = 1'b0;
                    end else begin
                        w[7:0] = b;
                        hi = 1'b1;
                        if (x == int'(v.wm1)) exp_q.push_back(w);
                    end
                end
            end
        end
    endtask

    task automatic launch(input vec_t v);
        build_exp(v);
        got_q.delete();
        @(negedge clk);
        src_addr = v.src; width_m1 = v.wm1; height_m1 = v.hm1;
        stride_w = v.stride; pix16 = v.two; phase = v.ph;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_and_compare(input vec_t v);
        string tag;
        int bad;
        while (!done) @(negedge clk);
        tag = v.two ? "R6 R7" : (v.ph ? "R3 R4 R7" : "R2 R4 R7");
        // R5 word count per line times lines
        chk(got_q.size() == exp_q.size(), "R5 word count", got_q.size(), exp_q.size());
        bad = -1;
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (bad < 0 && got_q[i] !== exp_q[i]) bad = i;
        if (bad >= 0) chk(1'b0, tag, got_q[bad], exp_q[bad]);
        else          chk(1'b1, tag, 0, 0);
        // R9 done with busy low after final word
        chk(done && !busy, "R9 done after last word", {done, busy}, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!out_valid && !mem_req && !busy && !done, "R1 reset state",
            {out_valid, mem_req, busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !mem_req && !busy && !done, "R1 after release",
            {out_valid, mem_req, busy, done}, 0);

        for (int i = 0; i < NV; i++) begin
            sink_mode = int'(VECS[i].stall);
            launch(VECS[i]);
            finish_and_compare(VECS[i]);
        end

        // R9 done holds while idle, then clears on the next start
        repeat (5) @(negedge clk);
        chk(done && !busy && !out_valid, "R9 done sticky", {done, busy, out_valid}, 4);

        // R8 stalled host: first word held, no reads issued
        sink_mode = 2;
        launch(VECS[1]);
        chk(!done, "R9 cleared by start", done, 0);
        while (!out_valid) @(negedge clk);
        begin
            logic [15:0] held;
            bit ok;
            held = out_data;
            ok = 1'b1;
            repeat (6) begin
                @(negedge clk);
                if (!out_valid || out_data !== held || mem_req) ok = 1'b0;
            end
            chk(ok, "R8 held word and no reads", out_data, held);
            chk(held == {pat(16'd101), 8'h00}, "R3 first word high byte", held,
                {pat(16'd101), 8'h00});
        end
        sink_mode = 0;
        finish_and_compare(VECS[1]);

        // R10 second start during a blit is ignored
        sink_mode = 1;
        launch(VECS[0]);
        repeat (4) @(negedge clk);
        chk(busy, "R10 busy before extra start", busy, 1);
        src_addr = 16'd5000; width_m1 = 10'd7; height_m1 = 10'd5;
        stride_w = 10'd3; pix16 = 1'b1; phase = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_and_compare(VECS[0]);
        chk(got_q.size() == 9, "R10 output unchanged by extra start", got_q.size(), 9);

        // R11 one outstanding read: no request while a response is pending
        sink_mode = 0;
        launch(VECS[2]);
        begin
            bit ok;
            ok = 1'b1;
            while (!done) begin
                if (mem_req && p_pend) ok = 1'b0;
                @(negedge clk);
            end
            chk(ok, "R11 single outstanding read", ok, 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule